// File: doc/BRIEF.md
# Four-Channel Current DAC Control Target on I2C

This block is a register target on a two-wire I2C bus that holds the settings of four bidirectional current DAC channels. It runs on the system clock and oversamples the bus clock and data lines through synchronizers. It finds start and stop conditions as data-line edges while the clock line is high. A 7-bit device address is matched, with a fixed five-bit prefix and two low bits taken from strap inputs. The target acknowledges a matching address by pulling the data line low during the ninth clock.

A write transaction carries a pointer byte and one data byte. A read transaction returns the register that the pointer currently selects. To read a chosen register, the controller writes the pointer, issues a repeated start, then reads. Each channel register is in sign-magnitude form. The top bit chooses between sourcing and sinking current, and the low seven bits give the step count. A step count of zero turns the channel off whatever the top bit says. The analog stage downstream uses the per-channel direction, level and active outputs.

Top module: `idac_i2c_regs`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1001_0 followed by strap_sel[1] and strap_sel[0]. Bit 0 is the direction bit: 0 for write, 1 for read. With strap_sel = 01 the write byte is 92h and the read byte is 93h. The acknowledge is SDA held low during the ninth SCL pulse.
- R2: After an address byte that does not match, the target drives no acknowledge and ignores every following byte until the next start condition. No register changes.
- R3: A write transaction stores its data byte in the register the pointer selects. The transaction is start, address with bit 0 = 0, pointer byte, data byte, stop. Pointer F8h selects channel 0, F9h channel 1, FAh channel 2 and FBh channel 3.
- R4: For channel i, ch_source[i] is register bit 7, where 1 means source and 0 means sink. ch_level[7i+6:7i] is register bits 6:0. ch_active[i] is 1 exactly when bits 6:0 are nonzero, whatever bit 7 holds.
- R5: After reset, all four registers are 00h, so every direction, level and active output is 0. The target does not pull SDA. The pointer is 00h, so a read returns 00h.
- R6: A write to a pointer outside F8h–FBh is acknowledged and then discarded. A read at such a pointer returns 00h.
- R7: A read transaction shifts out the selected register, most significant bit first, on eight SCL pulses. SDA changes only while SCL is low. After the eighth bit the target releases SDA. A NACK from the controller ends the read.
- R8: A data byte that follows the first data byte in the same write is not acknowledged and not stored. The pointer never increments.
- R9: A start condition at any point restarts address reception, including in the middle of a byte. A stop condition at any point returns the target to idle. A repeated start after the pointer byte keeps the new pointer for the read that follows.
- R10: Transfers work when each quarter of an SCL period lasts at least 6 system clocks, and also when the SCL period is much longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 2 | Low two bits of the device address |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open drain) |
| ch_source | output | 4 | Per channel: 1 = source, 0 = sink |
| ch_level | output | 28 | Per channel 7-bit step count, channel 0 in bits 6:0 |
| ch_active | output | 4 | Per channel: 1 when the step count is nonzero |

## Verification
The target sees a bus pin change two system clocks after it happens, because of the synchronizers. It reacts one clock after that. A register therefore updates about four system clocks after the SCL falling edge that ends the data byte. The bench leaves at least six clocks between any bus event and the next SCL edge. It checks the channel outputs only after the stop condition, well after the update. Read-back data and acknowledge bits are sampled in the middle of the SCL high phase, when the target's SDA drive has long settled. Transaction inputs are timed off the clock edges, so sampling never races the design.

// File: rtl/idr_pkg.sv
package idr_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACK,
      ST_SEND,
      ST_MACK,
      ST_SKIP
   } eng_st_e;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_PTR,
      PH_DATA,
      PH_MORE
   } byte_ph_e;

   function automatic byte_ph_e next_phase(input byte_ph_e cur);
      case (cur)
         PH_DEV:  return PH_PTR;
         PH_PTR:  return PH_DATA;
         default: return PH_MORE;
      endcase
   endfunction
endpackage

// File: rtl/idr_sync.sv
module idr_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("idr_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/idr_buscond.sv
module idr_buscond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_pin,
   input  logic sda_pin,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic [1:0] lines_s;
   logic       scl_d, sda_d;

   idr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_pin, sda_pin}),
      .q    (lines_s)
   );

   assign scl_lvl = lines_s[1];
   assign sda_lvl = lines_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/idr_engine.sv
module idr_engine
   import idr_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int STRAP_W = 2,
   parameter logic [ADDR_W-STRAP_W-1:0] DEV_PREFIX = 5'b10010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               scl_lvl,
   input  logic               sda_lvl,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  byte_t              rd_data,
   output byte_t              ptr,
   output logic               wr_en,
   output byte_t              wr_data,
   output logic               sda_oe
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
      $error("device address plus direction bit must fill one byte");
   end

   eng_st_e          st;
   byte_ph_e         ph;
   logic [CNT_W-1:0] cnt;
   byte_t            rx_sh, tx_sh;
   logic             is_read, mack;
   logic             addr_hit;

   assign addr_hit = (rx_sh[BYTE_W-1:1] == {DEV_PREFIX, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_DEV;
         cnt     <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         ptr     <= '0;
         is_read <= 1'b0;
         mack    <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (bus_start) begin
            st      <= ST_RECV;
            ph      <= PH_DEV;
            cnt     <= '0;
            is_read <= 1'b0;
         end else if (bus_stop) begin
            st <= ST_IDLE;
         end else begin
            case (st)
               ST_RECV: begin
                  if (scl_rise && cnt != FULL_BYTE) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL_BYTE) begin
                     case (ph)
                        PH_DEV: begin
                           if (addr_hit) begin
                              st      <= ST_ACK;
                              is_read <= rx_sh[0];
                           end else begin
                              st <= ST_SKIP;
                           end
                        end
                        PH_PTR: begin
                           ptr <= rx_sh;
                           st  <= ST_ACK;
                        end
                        PH_DATA: begin
                           wr_en   <= 1'b1;
                           wr_data <= rx_sh;
                           st      <= ST_ACK;
                        end
                        default: st <= ST_SKIP;
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (ph == PH_DEV && is_read) begin
                        st    <= ST_SEND;
                        tx_sh <= rd_data;
                     end else begin
                        st <= ST_RECV;
                        ph <= next_phase(ph);
                     end
                  end
               end
               ST_SEND: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        st <= ST_MACK;
                     end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st    <= ST_SEND;
                        tx_sh <= rd_data;
                        cnt   <= '0;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = (st == ST_ACK) || (st == ST_SEND && !tx_sh[BYTE_W-1]);

   // R9: a start always reopens address reception from bit zero
   assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (st == ST_RECV && ph == PH_DEV && cnt == '0));

   // R9: a stop always parks the engine
   assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (st == ST_IDLE));

   // R7: the data-line drive never moves while the clock line is high
   assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   // R2: once the address missed, nothing is stored
   assert_skip_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |=> !wr_en);
endmodule

// File: rtl/idr_regfile.sv
module idr_regfile
   import idr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int MAG_W = 7,
   parameter logic [BYTE_W-1:0] BASE_ADDR = 8'hF8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  byte_t                   wr_addr,
   input  byte_t                   wr_data,
   input  byte_t                   rd_addr,
   output byte_t                   rd_data,
   output logic [NUM_CH-1:0]       ch_source,
   output logic [NUM_CH*MAG_W-1:0] ch_level,
   output logic [NUM_CH-1:0]       ch_active
);
   localparam int REG_W = MAG_W + 1;

   if (REG_W != BYTE_W) begin : g_bad_mag
      $error("sign plus magnitude must fill one byte");
   end
   if (int'(BASE_ADDR) + NUM_CH > 256) begin : g_bad_window
      $error("register window wraps past FFh");
   end

   logic [NUM_CH*REG_W-1:0] q_flat;
   logic                    wr_hit;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam byte_t SLOT = BYTE_W'(int'(BASE_ADDR) + i);
      logic [REG_W-1:0] q_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else if (wr_en && wr_addr == SLOT) q_r <= wr_data;
      end

      assign q_flat[i*REG_W +: REG_W] = q_r;
      assign ch_source[i]              = q_r[MAG_W];
      assign ch_level[i*MAG_W +: MAG_W] = q_r[MAG_W-1:0];
      assign ch_active[i]              = |q_r[MAG_W-1:0];

      // R3: a mapped write lands in its own channel on the next cycle
      assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == SLOT) |=> (q_r == $past(wr_data)));
   end

   always_comb begin
      rd_data = '0;
      wr_hit  = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_addr == BYTE_W'(int'(BASE_ADDR) + i)) rd_data = q_flat[i*REG_W +: REG_W];
         if (wr_addr == BYTE_W'(int'(BASE_ADDR) + i)) wr_hit = 1'b1;
      end
   end

   // R6: a write outside the window leaves every register as it was
   assert_unmapped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hit) |=> $stable(q_flat));
endmodule

// File: rtl/idac_i2c_regs.sv
module idac_i2c_regs
   import idr_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int MAG_W = 7,
   parameter int STRAP_W = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [4:0] DEV_PREFIX = 5'b10010,
   parameter logic [7:0] BASE_ADDR = 8'hF8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [STRAP_W-1:0]      strap_sel,
   input  logic                    scl_in,
   input  logic                    sda_in,
   output logic                    sda_pull,
   output logic [NUM_CH-1:0]       ch_source,
   output logic [NUM_CH*MAG_W-1:0] ch_level,
   output logic [NUM_CH-1:0]       ch_active
);
   localparam int ADDR_W = BYTE_W - 1;

   if ($bits(DEV_PREFIX) + STRAP_W != ADDR_W) begin : g_bad_prefix
      $error("prefix and strap bits must make a 7-bit address");
   end

   logic  scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
   logic  wr_en;
   byte_t ptr, wr_data, rd_data;

   idr_buscond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_pin  (scl_in),
      .sda_pin  (sda_in),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop)
   );

   idr_engine #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .DEV_PREFIX(DEV_PREFIX)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap    (strap_sel),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .rd_data  (rd_data),
      .ptr      (ptr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sda_oe   (sda_pull)
   );

   idr_regfile #(.NUM_CH(NUM_CH), .MAG_W(MAG_W), .BASE_ADDR(BASE_ADDR)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (ptr),
      .wr_data  (wr_data),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .ch_source(ch_source),
      .ch_level (ch_level),
      .ch_active(ch_active)
   );
endmodule

// File: tb/sim_idac_i2c_regs.sv
module sim_idac_i2c_regs;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] DEV_W = 8'h92;
   localparam logic [7:0] DEV_R = 8'h93;
   localparam int NVEC = 8;
   // each entry: {pointer, data}
   localparam logic [15:0] VEC [NVEC] = '{
      16'hF8AA, 16'hF980, 16'hFA7F, 16'hFB01,
      16'hFBFF, 16'hF800, 16'hFC55, 16'hF712
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_low = 1'b0;
   logic        sda_line;
   logic        sda_pull;
   logic [3:0]  ch_source, ch_active;
   logic [27:0] ch_level;
   int          tests = 0;
   int          fails = 0;
   int          qclk = 10;
   bit          done = 1'b0;
   logic [7:0]  model [4];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = !(m_low || sda_pull);

   idac_i2c_regs u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_sel(2'b01),
      .scl_in   (scl),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .ch_source(ch_source),
      .ch_level (ch_level),
      .ch_active(ch_active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold();
      #(qclk*CLK_PERIOD);
   endtask

   task automatic do_start();
      m_low = 1'b0; hold(); scl = 1'b1; hold(); m_low = 1'b1; hold(); scl = 1'b0; hold();
   endtask

   task automatic do_stop();
      m_low = 1'b1; hold(); scl = 1'b1; hold(); m_low = 1'b0; hold(); hold();
   endtask

   task automatic put_bit(input logic b);
      m_low = !b; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
   endtask

   task automatic get_bit(output logic b);
      m_low = 1'b0; hold(); scl = 1'b1; hold(); b = sda_line; hold(); scl = 1'b0; hold();
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic get_byte(output logic [7:0] v, input logic last);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(last);
   endtask

   task automatic wr_txn(input logic [7:0] dev, input logic [7:0] p, input logic [7:0] d,
                         output logic a0, output logic a1, output logic a2);
      do_start();
      put_byte(dev, a0);
      put_byte(p, a1);
      put_byte(d, a2);
      do_stop();
   endtask

   task automatic rd_at(input logic [7:0] p, output logic a0, output logic a1,
                        output logic a2, output logic [7:0] d);
      do_start();
      put_byte(DEV_W, a0);
      put_byte(p, a1);
      do_start();
      put_byte(DEV_R, a2);
      get_byte(d, 1'b1);
      do_stop();
   endtask

   task automatic rd_cur(output logic a0, output logic [7:0] d);
      do_start();
      put_byte(DEV_R, a0);
      get_byte(d, 1'b1);
      do_stop();
   endtask

   task automatic chk_outputs(input string req);
      logic [3:0]  es, ea;
      logic [27:0] el;
      for (int c = 0; c < 4; c++) begin
         es[c]         = model[c][7];
         el[c*7 +: 7]  = model[c][6:0];
         ea[c]         = (model[c][6:0] != 7'd0);
      end
      chk({req, " source"}, 32'(ch_source), 32'(es));
      chk({req, " level"},  32'(ch_level),  32'(el));
      chk({req, " active"}, 32'(ch_active), 32'(ea));
   endtask

   function automatic logic mapped(input logic [7:0] p);
      return (p >= 8'hF8 && p <= 8'hFB);
   endfunction

   initial begin
      #(CLK_PERIOD*150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic a0, a1, a2, a3;
      logic [7:0] d;
      for (int c = 0; c < 4; c++) model[c] = 8'h00;
      #3;
      #(CLK_PERIOD*5);
      rst_n = 1'b1;
      #(CLK_PERIOD*5);

      // R5: reset state
      chk_outputs("R5 reset");
      chk("R5 sda released", 32'(sda_pull), 32'd0);
      rd_cur(a0, d);
      chk("R5 R1 read address ack", 32'(a0), 32'd1);
      chk("R5 pointer 00h reads 00h", 32'(d), 32'h00);

      // table walk: R1 R3 R4 R6 R7
      for (int k = 0; k < NVEC; k++) begin
         logic [7:0] p, v, exp_rd;
         p = VEC[k][15:8];
         v = VEC[k][7:0];
         wr_txn(DEV_W, p, v, a0, a1, a2);
         chk("R1 write address ack", 32'(a0), 32'd1);
         chk("R3 R6 pointer ack", 32'(a1), 32'd1);
         chk("R3 R6 data ack", 32'(a2), 32'd1);
         if (mapped(p)) model[p - 8'hF8] = v;
         chk_outputs(mapped(p) ? "R3 R4 outputs" : "R6 unmapped outputs");
         exp_rd = mapped(p) ? v : 8'h00;
         rd_at(p, a0, a1, a2, d);
         chk("R9 repeated start read ack", 32'(a2), 32'd1);
         chk(mapped(p) ? "R7 readback" : "R6 unmapped read", 32'(d), 32'(exp_rd));
      end

      // R8: extra data byte refused, pointer unchanged
      do_start();
      put_byte(DEV_W, a0);
      put_byte(8'hFA, a1);
      put_byte(8'h11, a2);
      put_byte(8'h22, a3);
      do_stop();
      model[2] = 8'h11;
      chk("R8 first data ack", 32'(a2), 32'd1);
      chk("R8 extra byte nack", 32'(a3), 32'd0);
      chk_outputs("R8 outputs");
      rd_cur(a0, d);
      chk("R8 no pointer increment", 32'(d), 32'h11);

      // R2: wrong device address
      wr_txn(8'h90, 8'hF9, 8'h33, a0, a1, a2);
      chk("R2 no address ack", 32'(a0), 32'd0);
      chk("R2 following bytes not acked", 32'({a1, a2}), 32'd0);
      chk_outputs("R2 outputs unchanged");
      do_start();
      put_byte(8'h97, a0);
      do_stop();
      chk("R2 wrong read address not acked", 32'(a0), 32'd0);

      // R9: start in the middle of a byte, then a normal write
      do_start();
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      wr_txn(DEV_W, 8'hF9, 8'h5A, a0, a1, a2);
      model[1] = 8'h5A;
      chk("R9 write after aborted byte", 32'({a0, a1, a2}), 32'h7);
      chk_outputs("R9 outputs");

      // R9: stop before the data byte stores nothing
      do_start();
      put_byte(DEV_W, a0);
      put_byte(8'hF8, a1);
      do_stop();
      chk_outputs("R9 stop before data");

      // R10: short and long SCL phases
      qclk = 6;
      wr_txn(DEV_W, 8'hFB, 8'h3C, a0, a1, a2);
      model[3] = 8'h3C;
      chk("R10 fast write acks", 32'({a0, a1, a2}), 32'h7);
      rd_at(8'hFB, a0, a1, a2, d);
      chk("R10 fast readback", 32'(d), 32'h3C);
      qclk = 60;
      wr_txn(DEV_W, 8'hF8, 8'hC5, a0, a1, a2);
      model[0] = 8'hC5;
      chk("R10 slow write acks", 32'({a0, a1, a2}), 32'h7);
      rd_at(8'hF8, a0, a1, a2, d);
      chk("R10 R7 slow readback", 32'(d), 32'hC5);
      chk_outputs("R10 outputs");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule